// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port of a chip. A test clock and a mode-select line drive the standard sixteen-state controller. A serial data line goes in and another comes out. Between them sits one of three registers: a 4-bit instruction register, a single-stage bypass register, or a chain of boundary cells. The chain has one cell per pin-level signal and is 117 cells long by default.

The active instruction decides three things: which register goes between the serial ports, whether the pins carry the core's values or the boundary update latches, and whether the core logic is held in reset. An external tester or an upstream scan chain uses the block to sample pin states while the chip runs normally. It can also preload known output values and then take over the pins. When another device on the board is under test, the block shortens its own scan path to a single flip-flop.

Shift order is fixed. Instruction bits and chain bits enter at the most significant end, and the least significant stage drives the serial output, so bit 0 leaves first. Boundary cell 0 is nearest the serial output, and cell N-1 takes the serial input.

Top module: `tap_port`

## Requirements
- R1: After `trst_n` is released and the controller sits in Test-Logic-Reset, the active instruction is bypass: `sys_rst_req`=0, `bs_mode`=0, `tdo_oe`=0, and `pin_out` equals `core_out`.
- R2: In Capture-IR the instruction shift stage loads the value 4'b0001. The first four bits shifted out on `tdo` in Shift-IR are therefore 1, 0, 0, 0.
- R3: The active instruction, and so `sys_rst_req` and `bs_mode`, does not change during Capture-IR, Shift-IR or Exit1-IR. It takes the shifted value only at the rising `tck` edge that leaves Update-IR.
- R4: Opcode 4'b1111 (bypass) places one flip-flop between `tdi` and `tdo`. Capture-DR loads it with 0, so the first bit out of a data scan is 0 and every later bit is the `tdi` bit of the previous shift clock.
- R5: Any opcode other than 4'b0000 and 4'b0010 behaves as bypass (for example 4'b0101). It gives the same one-stage path, `sys_rst_req`=0 and `bs_mode`=0.
- R6: Opcode 4'b0010 (sample/preload) selects the boundary chain. Capture-DR snapshots `pin_in`, and the snapshot leaves on `tdo` cell 0 first. `pin_out` keeps following `core_out` even after Update-DR.
- R7: Values loaded into the boundary update latches by Update-DR under sample/preload appear on `pin_out` in the first cycle after opcode 4'b0000 becomes active.
- R8: Opcode 4'b0000 (external test) selects the boundary chain and raises `bs_mode` and `sys_rst_req`. `pin_out` then shows the update latches: Capture-DR snapshots `pin_in`, and Update-DR puts the newly shifted data on `pin_out`.
- R9: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R10: Five rising `tck` edges with `tms`=1 bring the controller to Test-Logic-Reset from any state, and bypass becomes active there.
- R11: Driving `trst_n` low makes bypass active at once, without a `tck` edge: `sys_rst_req` falls and `pin_out` returns to `core_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset; asserted at once, released on `tck` |
| tms | input | 1 | Controller mode select, sampled on the rising `tck` edge |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, updated on the falling `tck` edge |
| tdo_oe | output | 1 | Output enable for `tdo`, high only in the shift states |
| core_out | input | N_CELLS | Values the core wants on the pins in normal operation |
| pin_in | input | N_CELLS | Values observed at the pins, captured in Capture-DR |
| pin_out | output | N_CELLS | Values sent to the pin drivers, data and enables alike |
| bs_mode | output | 1 | High when the boundary update latches own the pins |
| sys_rst_req | output | 1 | Reset request to the core logic, high under external test |

## Verification
The bench shifts every instruction in from the capture pattern. A design that loaded a different capture value, or shifted from the wrong end, would put something other than 1,0,0,0 on `tdo`. Just before the Update-IR edge it checks that the reset request has not moved yet, which catches a decoder fed from the shift stage instead of the held instruction. Bypass scans check for the leading 0 and the one-clock delay, with both the bypass opcode and an unassigned one, so a missing default decode or a bypass stage that keeps its old value shows up as a wrong first bit. Further checks cover a preload that must stay off the pins under sample yet appear at once under external test, the five-ones return to reset, and the asynchronous reset, where a design that waited for a clock edge would still be holding the reset request.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_TLR,
    S_RTI,
    S_SEL_DR,
    S_CAP_DR,
    S_SH_DR,
    S_EX1_DR,
    S_PA_DR,
    S_EX2_DR,
    S_UP_DR,
    S_SEL_IR,
    S_CAP_IR,
    S_SH_IR,
    S_EX1_IR,
    S_PA_IR,
    S_EX2_IR,
    S_UP_IR
  } tap_state_e;

  localparam int          IR_W       = 4;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      S_TLR:    state_d = tms ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms ? S_UP_DR  : S_PA_DR;
      S_PA_DR:  state_d = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: state_d = tms ? S_UP_DR  : S_SH_DR;
      S_UP_DR:  state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms ? S_UP_IR  : S_PA_IR;
      S_PA_IR:  state_d = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: state_d = tms ? S_UP_IR  : S_SH_IR;
      S_UP_IR:  state_d = tms ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= S_TLR;
    else        state <= state_d;
  end

  // Checker-side count of consecutive high TMS samples, saturating at five.
  logic [2:0] ones_cnt;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)             ones_cnt <= 3'd0;
    else if (!tms)          ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_cnt == 3'd5) |-> (state == S_TLR)); // R10

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output logic       sel_bsr,
  output logic       extest
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  logic            sr_cap, sr_sh, act_load, act_clr;

  assign sr_cap   = (state == S_CAP_IR);
  assign sr_sh    = (state == S_SH_IR);
  assign act_load = (state == S_UP_IR);
  assign act_clr  = (state == S_TLR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      ir_sr <= '0;
    else if (sr_cap) ir_sr <= IR_CAPTURE;
    else if (sr_sh)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        ir_q <= OP_BYPASS;
    else if (act_clr)  ir_q <= OP_BYPASS;
    else if (act_load) ir_q <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

  always_comb begin
    extest  = 1'b0;
    sel_bsr = 1'b0;
    unique case (ir_q)
      OP_EXTEST: begin extest = 1'b1; sel_bsr = 1'b1; end
      OP_SAMPLE: sel_bsr = 1'b1;
      default:   sel_bsr = 1'b0;
    endcase
  end

  AST_IR_CAPTURE_VALUE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_CAP_IR) |=> (ir_sr == IR_CAPTURE)); // R2

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (state != S_UP_IR && state != S_TLR) |=> $stable(ir_q)); // R3

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
  parameter int N_CELLS = 117
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               sh_en,
  input  logic               up_en,
  input  logic               tdi,
  input  logic [N_CELLS-1:0] pin_in,
  output logic               scan_out,
  output logic [N_CELLS-1:0] upd_q
);

  logic [N_CELLS-1:0] sr;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic sin;
    if (i == N_CELLS - 1) begin : g_head
      assign sin = tdi;
    end else begin : g_body
      assign sin = sr[i+1];
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      sr[i] <= 1'b0;
      else if (cap_en) sr[i] <= pin_in[i];
      else if (sh_en)  sr[i] <= sin;
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)     upd_q[i] <= 1'b0;
      else if (up_en) upd_q[i] <= sr[i];
    end
  end

  assign scan_out = sr[0];

  AST_BSR_LATCH_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !up_en |=> $stable(upd_q)); // R7

  AST_BSR_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    cap_en |=> (sr == $past(pin_in))); // R6

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int N_CELLS = 117
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [N_CELLS-1:0] core_out,
  input  logic [N_CELLS-1:0] pin_in,
  output logic [N_CELLS-1:0] pin_out,
  output logic               bs_mode,
  output logic               sys_rst_req
);

  // Reset: asserted immediately, released after two tck edges.
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e state;
  logic       ir_lsb, sel_bsr, extest;
  logic       bsr_out;
  logic [N_CELLS-1:0] upd_q;
  logic       byp_q;
  logic       in_sh_dr, in_sh_ir;
  logic       tdo_d;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .tdi     (tdi),
    .ir_lsb  (ir_lsb),
    .sel_bsr (sel_bsr),
    .extest  (extest)
  );

  tap_bsr #(.N_CELLS(N_CELLS)) u_bsr (
    .tck      (tck),
    .rst_n    (rst_n),
    .cap_en   (sel_bsr && state == S_CAP_DR),
    .sh_en    (sel_bsr && state == S_SH_DR),
    .up_en    (sel_bsr && state == S_UP_DR),
    .tdi      (tdi),
    .pin_in   (pin_in),
    .scan_out (bsr_out),
    .upd_q    (upd_q)
  );

  assign in_sh_dr = (state == S_SH_DR);
  assign in_sh_ir = (state == S_SH_IR);

  // Bypass stage: takes tdi while shifting, a constant zero otherwise.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= in_sh_dr & tdi;
  end

  always_comb begin
    if (in_sh_ir)     tdo_d = ir_lsb;
    else if (sel_bsr) tdo_d = bsr_out;
    else              tdo_d = byp_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= in_sh_ir | in_sh_dr;
    end
  end

  assign bs_mode     = extest;
  assign sys_rst_req = extest;
  assign pin_out     = bs_mode ? upd_q : core_out;

  AST_TLR_BYPASS: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_TLR) |=> (!sel_bsr && !sys_rst_req)); // R10

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_CAP_DR) |=> !byp_q); // R4

  AST_TDO_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == S_SH_DR || state == S_SH_IR)); // R9

endmodule

// File: tb/tap_port_tb.sv
`timescale 1ns/1ps
module tap_port_tb;

  localparam int NB = 117;

  logic          tck;
  logic          trst_n;
  logic          tms;
  logic          tdi;
  logic          tdo;
  logic          tdo_oe;
  logic [NB-1:0] core_out;
  logic [NB-1:0] pin_in;
  logic [NB-1:0] pin_out;
  logic          bs_mode;
  logic          sys_rst_req;

  tap_port #(.N_CELLS(NB)) u_dut (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .tdi         (tdi),
    .tdo         (tdo),
    .tdo_oe      (tdo_oe),
    .core_out    (core_out),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .bs_mode     (bs_mode),
    .sys_rst_req (sys_rst_req)
  );

  initial tck = 1'b0;
  always #2.5 tck = ~tck;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Scoreboard: expected serial bits and their requirement tags.
  logic  exp_bit_q[$];
  string exp_req_q[$];
  logic  act_bit;
  event  act_ev;

  task automatic push_exp(input string req, input logic b);
    exp_bit_q.push_back(b);
    exp_req_q.push_back(req);
  endtask

  initial begin
    forever begin
      @(act_ev);
      checks++;
      if (exp_bit_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected tdo bit actual=%0b expected=none", act_bit);
      end else begin
        logic  e;
        string r;
        e = exp_bit_q.pop_front();
        r = exp_req_q.pop_front();
        if (act_bit !== e) begin
          errors++;
          $display("FAIL %s tdo bit actual=%0b expected=%0b", r, act_bit, e);
        end
      end
    end
  end

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pat(input int s);
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (((i * s) + (s / 3)) % 7) > 2;
    return v;
  endfunction

  // One tck cycle: drive inputs while tck is low, return tdo seen before the rising edge.
  task automatic tick(input logic m, input logic d, output logic so);
    tms = m;
    tdi = d;
    #0.5;
    so = tdo;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic tk(input logic m);
    logic junk;
    tick(m, 1'b0, junk);
  endtask

  // From Run-Test/Idle: load an opcode, back to Run-Test/Idle.
  task automatic load_ir(input logic [3:0] code);
    logic b;
    logic old_req;
    old_req = sys_rst_req;
    tk(1'b1); tk(1'b1); tk(1'b0); tk(1'b0);
    push_exp("R2", 1'b1); push_exp("R2", 1'b0);
    push_exp("R2", 1'b0); push_exp("R2", 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], b);
      act_bit = b;
      ->act_ev;
    end
    tk(1'b1);
    check("R3 before update", {{(NB-1){1'b0}}, sys_rst_req}, {{(NB-1){1'b0}}, old_req});
    tk(1'b0);
  endtask

  // From Run-Test/Idle: scan len bits of din through the selected data register.
  task automatic scan_dr(input int len, input logic [NB-1:0] din);
    logic b;
    tk(1'b1); tk(1'b0); tk(1'b0);
    for (int i = 0; i < len; i++) begin
      if (i == 0) check("R9 oe in shift", {{(NB-1){1'b0}}, tdo_oe}, {{(NB-1){1'b0}}, 1'b1});
      tick(i == len - 1, din[i], b);
      act_bit = b;
      ->act_ev;
    end
    tk(1'b1); tk(1'b0);
  endtask

  function automatic logic [NB-1:0] b1(input logic x);
    return {{(NB-1){1'b0}}, x};
  endfunction

  initial begin
    logic [NB-1:0] c0, p1, p2, d1, d2, bp;
    c0 = pat(5);  p1 = pat(3);  p2 = pat(11);
    d1 = pat(13); d2 = pat(17); bp = '0;
    bp[7:0] = 8'b1011_0110;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    core_out = c0; pin_in = p1;
    @(negedge tck); #1;
    repeat (2) tk(1'b1);
    trst_n = 1'b1;
    repeat (3) tk(1'b1);

    // R1 reset state
    check("R1 sys_rst_req", b1(sys_rst_req), b1(1'b0));
    check("R1 bs_mode", b1(bs_mode), b1(1'b0));
    check("R1 tdo_oe", b1(tdo_oe), b1(1'b0));
    check("R1 pins follow core", pin_out, c0);
    tk(1'b0);
    check("R9 oe idle", b1(tdo_oe), b1(1'b0));

    // R6 sample: snapshot p1, preload d1, pins still on core
    load_ir(4'b0010);
    check("R6 no reset request", b1(sys_rst_req), b1(1'b0));
    for (int i = 0; i < NB; i++) push_exp("R6", p1[i]);
    scan_dr(NB, d1);
    check("R6 pins stay on core", pin_out, c0);

    // R7 R8 external test: preload visible at once
    load_ir(4'b0000);
    check("R3 after update", b1(sys_rst_req), b1(1'b1));
    check("R8 bs_mode", b1(bs_mode), b1(1'b1));
    check("R7 preload on pins", pin_out, d1);
    pin_in = p2;
    for (int i = 0; i < NB; i++) push_exp("R8", p2[i]);
    scan_dr(NB, d2);
    check("R8 new data on pins", pin_out, d2);

    // R4 bypass
    load_ir(4'b1111);
    check("R4 reset request off", b1(sys_rst_req), b1(1'b0));
    check("R4 pins back on core", pin_out, c0);
    push_exp("R4", 1'b0);
    for (int i = 0; i < 7; i++) push_exp("R4", bp[i]);
    scan_dr(8, bp);

    // R5 unassigned opcode acts as bypass
    load_ir(4'b0000);
    load_ir(4'b0101);
    check("R5 reset request", b1(sys_rst_req), b1(1'b0));
    check("R5 bs_mode", b1(bs_mode), b1(1'b0));
    push_exp("R5", 1'b0);
    for (int i = 0; i < 7; i++) push_exp("R5", bp[i]);
    scan_dr(8, bp);

    // R10 five ones return to reset
    load_ir(4'b0000);
    check("R10 extest active first", b1(sys_rst_req), b1(1'b1));
    repeat (5) tk(1'b1);
    check("R10 reset request", b1(sys_rst_req), b1(1'b0));
    check("R10 pins on core", pin_out, c0);
    tk(1'b0);

    // R11 asynchronous reset
    load_ir(4'b0000);
    check("R11 extest active first", b1(sys_rst_req), b1(1'b1));
    #0.7;
    trst_n = 1'b0;
    #0.3;
    check("R11 reset request", b1(sys_rst_req), b1(1'b0));
    check("R11 pins on core", pin_out, c0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    repeat (3) tk(1'b1);
    tk(1'b0);

    #1;
    checks++;
    if (exp_bit_q.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard leftover actual=%0d expected=0", exp_bit_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule